// File: doc/BRIEF.md
# Parallel-Digit Binary Field Multiplier (GF(2^163))

This block multiplies two elements of the binary extension field GF(2^163) in polynomial basis. Bit i of each 163-bit word is the coefficient of x^i. The second operand is cut into 41-bit slices: three full slices and a 40-bit top slice. Each slice is multiplied carry-lessly by the whole first operand, and all slices are handled at once. The slice products are shifted to their bit offsets and XORed into a 325-bit unreduced product.

A fold network then reduces that product modulo the field polynomial, and the 163-bit result is captured in an output register. A caller presents both operands with a one-cycle strobe. The product and its strobe come back on the next clock edge. A new pair may be issued on every cycle.

Top module: `gf163_digit_mul`

## Requirements
- R1: `valid_out` is high in exactly the cycles that follow a clock edge at which `valid_in` was high, so the latency is one cycle.
- R2: On a strobed edge, `result` becomes op_a·op_b reduced modulo P(x) = x^163 + x^7 + x^6 + x^3 + 1, with carry-less coefficient arithmetic and bit i holding the coefficient of x^i. For example, x^162·x gives x^7+x^6+x^3+1, which is 0xC9.
- R3: If either operand is zero on a strobed edge, the registered result is zero.
- R4: If either operand is the element 1 (only bit 0 set), the registered result equals the other operand.
- R5: The product is the same whichever operand is routed to the sliced input, so that (a,b) and (b,a) give identical results.
- R6: On an edge where `valid_in` is low, `result` keeps its previous value, whatever the operand inputs carry.
- R7: While `rst` is high at a clock edge, `valid_out` and `result` are cleared to zero.
- R8: Products whose unreduced degree lies anywhere from 0 to 324 are reduced correctly. This covers all-ones operands and single-term operands on each slice boundary (bits 40/41, 81/82 and 122/123).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Operand strobe |
| op_a | input | 163 | First field operand, multiplied whole |
| op_b | input | 163 | Second field operand, cut into slices |
| valid_out | output | 1 | Result strobe, one cycle after `valid_in` |
| result | output | 163 | Registered reduced product |

## Verification
Every fault in this datapath shows up at `result` in the cycle after the strobe, because nothing is held across operations apart from the output register. A slice that is misplaced or the wrong width corrupts only products that use terms of that slice. Sweeping single-term operands against a term placed on each slice boundary therefore points to the slice at fault. A wrong fold tap leaves the correct low bits but errs on every product of degree 163 or higher, and single-term sweeps show these errors position by position. A broken hold or a broken strobe path shows up on the first idle cycle after a strobe.

// File: rtl/gf163_pkg.sv
package gf163_pkg;

    // Field and slicing constants
    localparam int FIELD_M  = 163;
    localparam int DIGIT_W  = 41;

    // Low-order terms of the field polynomial: x^7 + x^6 + x^3 + 1
    localparam logic [FIELD_M-1:0] POLY_TAIL = 163'h0C9;

    // Number of slices needed to cover m bits with slices of width d
    function automatic int digit_count(input int m, input int d);
        return (m + d - 1) / d;
    endfunction

    // Width of slice idx: full width, except the top slice takes the remainder
    function automatic int digit_width(input int idx, input int m, input int d);
        int n;
        n = digit_count(m, d);
        if (idx == n - 1)
            return m - (n - 1) * d;
        return d;
    endfunction

endpackage

// File: rtl/gf_digit_clmul.sv
// Carry-less product of a full m-bit operand and one dw-bit slice.
module gf_digit_clmul #(
    parameter int M  = 163,
    parameter int DW = 41
) (
    input  logic [M-1:0]    a,
    input  logic [DW-1:0]   dig,
    output logic [M+DW-2:0] prod
);
    always_comb begin
        prod = '0;
        for (int j = 0; j < DW; j++) begin
            if (dig[j])
                prod = prod ^ ({{(DW-1){1'b0}}, a} << j);
        end
    end
endmodule

// File: rtl/gf_fold_reduce.sv
// Reduces a (2m-1)-bit polynomial modulo x^m + POLY_TAIL by folding from the top.
module gf_fold_reduce #(
    parameter int M = 163,
    parameter logic [M-1:0] POLY_TAIL = '0
) (
    input  logic [2*M-2:0] wide,
    output logic [M-1:0]   red
);
    logic [2*M-2:0] work;

    always_comb begin
        work = wide;
        for (int i = 2*M-2; i >= M; i--) begin
            if (work[i])
                work[i-M +: M] = work[i-M +: M] ^ POLY_TAIL;
        end
        red = work[M-1:0];
    end
endmodule

// File: rtl/gf163_digit_mul.sv
module gf163_digit_mul #(
    parameter int FIELD_M = gf163_pkg::FIELD_M,
    parameter int DIGIT_W = gf163_pkg::DIGIT_W,
    parameter logic [FIELD_M-1:0] POLY_TAIL = gf163_pkg::POLY_TAIL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_in,
    input  logic [FIELD_M-1:0] op_a,
    input  logic [FIELD_M-1:0] op_b,
    output logic               valid_out,
    output logic [FIELD_M-1:0] result
);
    localparam int NUM_DIGITS = gf163_pkg::digit_count(FIELD_M, DIGIT_W);
    localparam int FULL_W     = 2 * FIELD_M - 1;

    logic [FULL_W-1:0] placed [NUM_DIGITS];
    logic [FULL_W-1:0] wide_prod;
    logic [FIELD_M-1:0] reduced;

    // One carry-less slice multiplier per slice of op_b, all working at once
    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_slice
        localparam int DW = gf163_pkg::digit_width(g, FIELD_M, DIGIT_W);
        localparam int LO = g * DIGIT_W;
        logic [FIELD_M+DW-2:0] part;

        gf_digit_clmul #(.M(FIELD_M), .DW(DW)) u_clmul (
            .a    (op_a),
            .dig  (op_b[LO +: DW]),
            .prod (part)
        );

        assign placed[g] = {{(FULL_W-(FIELD_M+DW-1)){1'b0}}, part} << LO;
    end

    always_comb begin
        wide_prod = '0;
        for (int k = 0; k < NUM_DIGITS; k++)
            wide_prod = wide_prod ^ placed[k];
    end

    gf_fold_reduce #(.M(FIELD_M), .POLY_TAIL(POLY_TAIL)) u_reduce (
        .wide (wide_prod),
        .red  (reduced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_out <= 1'b0;
            result    <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in)
                result <= reduced;
        end
    end
endmodule

// File: rtl/gf163_mul_chk.sv
module gf163_mul_chk #(
    parameter int M = 163
) (
    input logic         clk,
    input logic         rst,
    input logic         valid_in,
    input logic [M-1:0] op_a,
    input logic [M-1:0] op_b,
    input logic         valid_out,
    input logic [M-1:0] result
);
    localparam logic [M-1:0] ONE = {{(M-1){1'b0}}, 1'b1};

    // R1
    strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> valid_out);

    // R1
    no_spurious_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !valid_out);

    // R3
    zero_operand_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && (op_a == '0 || op_b == '0)) |=> (result == '0));

    // R4
    unit_b_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_b == ONE) |=> (result == $past(op_a)));

    // R4
    unit_a_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_a == ONE) |=> (result == $past(op_b)));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> $stable(result));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_out && result == '0));
endmodule

bind gf163_digit_mul gf163_mul_chk #(.M(FIELD_M)) u_mul_chk (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (valid_in),
    .op_a      (op_a),
    .op_b      (op_b),
    .valid_out (valid_out),
    .result    (result)
);

// File: tb/tb_gf163_digit_mul.sv
module tb_gf163_digit_mul;
    localparam int M = 163;
    localparam int WATCHDOG_CYCLES = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         valid_in = 1'b0;
    logic [M-1:0] op_a = '0;
    logic [M-1:0] op_b = '0;
    logic         valid_out;
    logic [M-1:0] result;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gf163_digit_mul dut (
        .clk       (clk),
        .rst       (rst),
        .valid_in  (valid_in),
        .op_a      (op_a),
        .op_b      (op_b),
        .valid_out (valid_out),
        .result    (result)
    );

    // Bit-serial shift-and-add reference, MSB of b first
    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc;
        logic         top;
        acc = '0;
        for (int i = M-1; i >= 0; i--) begin
            top = acc[M-1];
            acc = acc << 1;
            if (top) acc = acc ^ 163'h0C9;
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    function automatic logic [M-1:0] rand_elem();
        logic [191:0] r;
        r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return r[M-1:0];
    endfunction

    function automatic logic [M-1:0] term(input int k);
        logic [M-1:0] v;
        v = '0;
        v[k] = 1'b1;
        return v;
    endfunction

    task automatic check(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, got, exp);
        end
    endtask

    // Strobe one pair at a negedge, sample the next negedge (one register on the path)
    task automatic issue(input string req, input logic [M-1:0] a, input logic [M-1:0] b,
                         input logic [M-1:0] exp);
        op_a     = a;
        op_b     = b;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check_bit({req, " R1 strobe"}, valid_out, 1'b1);
        check(req, result, exp);
    endtask

    // Idle cycle with disturbed operands: result holds, no strobe (R6, R1)
    task automatic idle_hold(input logic [M-1:0] held);
        op_a = rand_elem();
        op_b = rand_elem();
        @(negedge clk);
        check_bit("R1 idle strobe", valid_out, 1'b0);
        check("R6 hold", result, held);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [M-1:0] a, b, p, q;
        int sl [8];
        sl = '{0, 40, 41, 81, 82, 122, 123, 162};

        // R7: reset state
        op_a = rand_elem();
        op_b = rand_elem();
        valid_in = 1'b1;
        repeat (3) @(negedge clk);
        check_bit("R7 valid_out", valid_out, 1'b0);
        check("R7 result", result, '0);
        valid_in = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        // R2: explicit fold value x^162 * x = 0xC9
        issue("R2 fold", term(162), term(1), 163'h0C9);
        idle_hold(163'h0C9);

        // R3: zero operands
        issue("R3 zero b", rand_elem(), '0, '0);
        issue("R3 zero a", '0, rand_elem(), '0);

        // R4: identity
        a = rand_elem();
        issue("R4 one b", a, term(0), a);
        a = rand_elem();
        issue("R4 one a", term(0), a, a);

        // R8: all ones
        a = '1;
        issue("R8 all-ones sq", a, a, ref_mul(a, a));
        b = rand_elem();
        issue("R8 all-ones a", a, b, ref_mul(a, b));

        // R8: single-term sweep against slice-boundary terms
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < M; i++) begin
                issue("R8 term sweep", term(i), term(sl[s]), ref_mul(term(i), term(sl[s])));
            end
        end

        // R2 and R5: random operands, both orders, then idle hold
        for (int n = 0; n < 300; n++) begin
            a = rand_elem();
            b = rand_elem();
            p = ref_mul(a, b);
            issue("R2 random", a, b, p);
            q = result;
            issue("R5 swapped", b, a, q);
            idle_hold(q);
        end

        // R2: back-to-back strobes on consecutive cycles
        a = rand_elem();
        b = rand_elem();
        op_a = a; op_b = b; valid_in = 1'b1;
        @(negedge clk);
        check("R2 burst 1", result, ref_mul(a, b));
        op_a = b; op_b = term(5);
        @(negedge clk);
        valid_in = 1'b0;
        check_bit("R1 burst strobe", valid_out, 1'b1);
        check("R2 burst 2", result, ref_mul(b, term(5)));

        // R7: reset mid-run clears state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R7 re-reset", result, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule